// File: doc/BRIEF.md
# Gradient Tensor Stage for Optical Flow

This block is the front end of a gradient-based optical flow pipeline. It takes two pixel streams in raster order, both already smoothed by a 2-D Gaussian. One is the current frame. The other is the previous frame, fetched back from external storage. The two pixels at the same position arrive together on one handshake. For every pixel the block forms three central-difference gradients: along the row (Ix), down the column (Iy) and between frames (It). From these it produces the five products that make up the motion structure tensor. Each product keeps full signed precision.

Two line memories of current-frame pixels supply the vertical taps. A third line memory holds the frame difference of the row above, so that every term refers to the same pixel. Border pixels, where the mask would reach outside the image, get a zero gradient. Every input pixel still yields exactly one output, and that output carries start-of-frame and end-of-line markers. After the last pixel of a frame, the block drops its ready and drains its final line internally.

Top module: `grad_tensor_stage`

## Requirements
- R1: Ix at (r,c) equals cur(r,c+1) - cur(r,c-1), and is 0 in column 0 and column LINE_W-1; out_ixx carries Ix*Ix.
- R2: Iy at (r,c) equals cur(r+1,c) - cur(r-1,c), and is 0 in row 0 and row LINES-1; out_iyy carries Iy*Iy.
- R3: It at (r,c) equals cur(r,c) - prev(r,c); out_ixt carries Ix*It and out_iyt carries Iy*It.
- R4: All products are signed two's complement, 2*(PIX_W+2) bits wide, and never truncated; out_ixy carries Ix*Iy.
- R5: Each frame of LINE_W*LINES accepted pixels yields exactly LINE_W*LINES outputs (out_valid high for one cycle each), in raster order. After reset, out_valid is 0 and in_ready is 1.
- R6: out_sof is 1 only on the output for pixel (0,0). out_eol is 1 exactly on the outputs for column LINE_W-1.
- R7: With a pixel offered every cycle, the first output of a frame appears LINE_W+1 clock cycles after the cycle that accepts the frame's first pixel.
- R8: After the last pixel of a frame is accepted, in_ready stays 0 for exactly LINE_W+1 cycles while the last line drains, then returns to 1.
- R9: Cycles with in_valid low (outside the drain) advance nothing. They emit no output, and idle gaps of any length leave the results unchanged.
- R10: A pixel accepted with in_sof = 1 is taken as pixel (0,0) of a new frame, even when the previous frame was incomplete. No stale output from the abandoned frame is emitted after it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Pixel pair offered |
| in_ready | output | 1 | Pixel pair accepted when high with in_valid |
| in_sof | input | 1 | Offered pair is the first pixel of a frame |
| in_cur | input | PIX_W | Smoothed current-frame pixel, unsigned |
| in_prev | input | PIX_W | Smoothed previous-frame pixel at same position, unsigned |
| out_valid | output | 1 | Products valid this cycle |
| out_sof | output | 1 | Output belongs to pixel (0,0) |
| out_eol | output | 1 | Output belongs to last column |
| out_ixx | output | 2*(PIX_W+2) | Ix squared |
| out_iyy | output | 2*(PIX_W+2) | Iy squared |
| out_ixy | output | 2*(PIX_W+2) | Ix times Iy |
| out_ixt | output | 2*(PIX_W+2) | Ix times It |
| out_iyt | output | 2*(PIX_W+2) | Iy times It |

## Verification
The assertions assume three things about the inputs. Pixels are unsigned. in_sof comes only with the first pixel of a frame. A frame is otherwise a complete raster of LINE_W*LINES pairs, so the border-zero and tensor-inequality properties apply to the pixel that the markers name. The stimulus raises in_sof only on the first pixel of each frame. The one deliberately incomplete frame is followed at once by a fresh start-of-frame, and pixels are offered only while in_ready is high, so nothing is ever presented during the drain.

// File: rtl/gt_pkg.sv
package gt_pkg;

  // Index of each tensor product in the product array.
  typedef enum logic [2:0] {
    PR_XX = 3'd0,
    PR_YY = 3'd1,
    PR_XY = 3'd2,
    PR_XT = 3'd3,
    PR_YT = 3'd4
  } prod_e;

  localparam int NUM_PROD = 5;

  // Signed difference of two unsigned pixels plus one guard bit.
  function automatic int grad_width(input int pix_w);
    return pix_w + 2;
  endfunction

endpackage

// File: rtl/gt_raster_pos.sv
module gt_raster_pos #(
  parameter int LINE_W = 567,
  parameter int LINES  = 378,
  parameter int CW     = 10,
  parameter int RW     = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  input  logic          in_sof,
  output logic          in_ready,
  output logic          step,
  output logic          flushing,
  output logic          eff_sof,
  output logic [RW-1:0] cur_row,
  output logic [CW-1:0] cur_col
);

  localparam logic [RW-1:0] ROW_DRAIN = RW'(LINES);
  localparam logic [CW-1:0] COL_LAST  = CW'(LINE_W - 1);
  localparam logic [CW-1:0] COL_XTRA  = CW'(LINE_W);

  logic [RW-1:0] row_q, row_d;
  logic [CW-1:0] col_q, col_d;
  logic          take;

  always_comb begin
    flushing = (row_q == ROW_DRAIN);
    in_ready = !flushing;
    take     = in_valid && !flushing;
    step     = take || flushing;
    eff_sof  = take && in_sof;
    cur_row  = eff_sof ? '0 : row_q;
    cur_col  = eff_sof ? '0 : col_q;
  end

  always_comb begin
    row_d = cur_row;
    col_d = cur_col;
    if (cur_row == ROW_DRAIN) begin
      if (cur_col == COL_XTRA) begin
        row_d = '0;
        col_d = '0;
      end else begin
        col_d = cur_col + CW'(1);
      end
    end else if (cur_col == COL_LAST) begin
      row_d = cur_row + RW'(1);
      col_d = '0;
    end else begin
      col_d = cur_col + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      row_q <= '0;
      col_q <= '0;
    end else if (step) begin
      row_q <= row_d;
      col_q <= col_d;
    end
  end

  a_r9_hold_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !step |=> ($stable(row_q) && $stable(col_q)));

  a_r5_col_in_line: assert property (@(posedge clk) disable iff (!rst_n)
    (row_q != ROW_DRAIN) |-> (col_q < COL_XTRA));

endmodule

// File: rtl/gt_line_mem.sv
module gt_line_mem #(
  parameter int DW    = 8,
  parameter int DEPTH = 567,
  parameter int AW    = 10
) (
  input  logic          clk,
  input  logic          wr_en,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);

  logic [DW-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) mem[addr] <= wdata;
  end

  assign rdata = mem[addr];

endmodule

// File: rtl/gt_products.sv
module gt_products
  import gt_pkg::*;
#(
  parameter int GW = 10,
  parameter int PW = 20
) (
  input  logic signed [GW-1:0] ix,
  input  logic signed [GW-1:0] iy,
  input  logic signed [GW-1:0] it,
  output logic signed [PW-1:0] prod [NUM_PROD]
);

  logic signed [GW-1:0] opa [NUM_PROD];
  logic signed [GW-1:0] opb [NUM_PROD];

  always_comb begin
    opa[int'(PR_XX)] = ix;  opb[int'(PR_XX)] = ix;
    opa[int'(PR_YY)] = iy;  opb[int'(PR_YY)] = iy;
    opa[int'(PR_XY)] = ix;  opb[int'(PR_XY)] = iy;
    opa[int'(PR_XT)] = ix;  opb[int'(PR_XT)] = it;
    opa[int'(PR_YT)] = iy;  opb[int'(PR_YT)] = it;
  end

  for (genvar i = 0; i < NUM_PROD; i++) begin : g_mul
    logic signed [PW-1:0] ea;
    logic signed [PW-1:0] eb;
    assign ea      = opa[i];
    assign eb      = opb[i];
    assign prod[i] = ea * eb;
  end

endmodule

// File: rtl/grad_tensor_stage.sv
module grad_tensor_stage
  import gt_pkg::*;
#(
  parameter int PIX_W  = 8,
  parameter int LINE_W = 567,
  parameter int LINES  = 378
) (
  input  logic                            clk,
  input  logic                            rst_n,
  input  logic                            in_valid,
  output logic                            in_ready,
  input  logic                            in_sof,
  input  logic [PIX_W-1:0]                in_cur,
  input  logic [PIX_W-1:0]                in_prev,
  output logic                            out_valid,
  output logic                            out_sof,
  output logic                            out_eol,
  output logic signed [2*(PIX_W+2)-1:0]   out_ixx,
  output logic signed [2*(PIX_W+2)-1:0]   out_iyy,
  output logic signed [2*(PIX_W+2)-1:0]   out_ixy,
  output logic signed [2*(PIX_W+2)-1:0]   out_ixt,
  output logic signed [2*(PIX_W+2)-1:0]   out_iyt
);

  localparam int GW = grad_width(PIX_W);
  localparam int PW = 2 * GW;
  localparam int CW = $clog2(LINE_W + 1);
  localparam int RW = $clog2(LINES + 1);
  localparam int AW = $clog2(LINE_W);
  localparam logic [CW-1:0] COL_LAST  = CW'(LINE_W - 1);
  localparam logic [CW-1:0] COL_END   = CW'(LINE_W);
  localparam logic [RW-1:0] ROW_DRAIN = RW'(LINES);

  // Position tracking
  logic          step, flushing, eff_sof;
  logic [RW-1:0] cur_row;
  logic [CW-1:0] cur_col;

  gt_raster_pos #(
    .LINE_W(LINE_W), .LINES(LINES), .CW(CW), .RW(RW)
  ) u_pos (
    .clk      (clk),
    .rst_n    (rst_n),
    .in_valid (in_valid),
    .in_sof   (in_sof),
    .in_ready (in_ready),
    .step     (step),
    .flushing (flushing),
    .eff_sof  (eff_sof),
    .cur_row  (cur_row),
    .cur_col  (cur_col)
  );

  // Line memories
  logic             col_ok;
  logic [AW-1:0]    mem_addr;
  logic             mem_we;
  logic [PIX_W-1:0] new_pix;
  logic [PIX_W-1:0] up1_q;   // current frame, row above
  logic [PIX_W-1:0] up2_q;   // current frame, two rows above
  logic [GW-1:0]    dt_new;
  logic [GW-1:0]    dt_q;    // frame difference, row above

  always_comb begin
    col_ok   = (cur_col < COL_END);
    mem_addr = col_ok ? cur_col[AW-1:0] : '0;
    mem_we   = step && !flushing;
    new_pix  = flushing ? '0 : in_cur;
    dt_new   = $signed({2'b00, in_cur}) - $signed({2'b00, in_prev});
  end

  gt_line_mem #(.DW(PIX_W), .DEPTH(LINE_W), .AW(AW)) u_up1 (
    .clk(clk), .wr_en(mem_we), .addr(mem_addr), .wdata(new_pix), .rdata(up1_q)
  );

  gt_line_mem #(.DW(PIX_W), .DEPTH(LINE_W), .AW(AW)) u_up2 (
    .clk(clk), .wr_en(mem_we), .addr(mem_addr), .wdata(up1_q), .rdata(up2_q)
  );

  gt_line_mem #(.DW(GW), .DEPTH(LINE_W), .AW(AW)) u_dt (
    .clk(clk), .wr_en(mem_we), .addr(mem_addr), .wdata(dt_new), .rdata(dt_q)
  );

  // Stage 1: centre pixel is (cur_row-1, cur_col)
  logic                    s1_valid_q, s1_valid_d;
  logic                    s1_top_q,   s1_top_d;
  logic [CW-1:0]           s1_col_q,   s1_col_d;
  logic signed [GW-1:0]    s1_iy_q,    s1_iy_d;
  logic signed [GW-1:0]    s1_it_q,    s1_it_d;
  logic [PIX_W-1:0]        s1_left_q,  s1_left_d;
  logic [PIX_W-1:0]        left_q,     left_d;

  always_comb begin
    s1_valid_d = (cur_row != '0) && col_ok;
    s1_top_d   = (cur_row == RW'(1));
    s1_col_d   = cur_col;
    if ((cur_row == RW'(1)) || (cur_row == ROW_DRAIN))
      s1_iy_d = '0;
    else
      s1_iy_d = $signed({2'b00, new_pix}) - $signed({2'b00, up2_q});
    s1_it_d    = $signed(dt_q);
    s1_left_d  = left_q;
    left_d     = up1_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      s1_valid_q <= 1'b0;
      s1_top_q   <= 1'b0;
      s1_col_q   <= '0;
      s1_iy_q    <= '0;
      s1_it_q    <= '0;
      s1_left_q  <= '0;
      left_q     <= '0;
    end else if (step) begin
      s1_valid_q <= s1_valid_d;
      s1_top_q   <= s1_top_d;
      s1_col_q   <= s1_col_d;
      s1_iy_q    <= s1_iy_d;
      s1_it_q    <= s1_it_d;
      s1_left_q  <= s1_left_d;
      left_q     <= left_d;
    end
  end

  // Horizontal gradient: right neighbour is the current read of the row above
  logic signed [GW-1:0] ix_c;

  always_comb begin
    if ((s1_col_q == '0) || (s1_col_q == COL_LAST))
      ix_c = '0;
    else
      ix_c = $signed({2'b00, up1_q}) - $signed({2'b00, s1_left_q});
  end

  logic signed [PW-1:0] prod [NUM_PROD];

  gt_products #(.GW(GW), .PW(PW)) u_mul (
    .ix   (ix_c),
    .iy   (s1_iy_q),
    .it   (s1_it_q),
    .prod (prod)
  );

  // Output register
  logic out_valid_d, out_sof_d, out_eol_d;

  always_comb begin
    out_valid_d = step && s1_valid_q && !eff_sof;
    out_sof_d   = s1_top_q && (s1_col_q == '0);
    out_eol_d   = (s1_col_q == COL_LAST);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
    end else begin
      out_valid <= out_valid_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_sof <= 1'b0;
      out_eol <= 1'b0;
      out_ixx <= '0;
      out_iyy <= '0;
      out_ixy <= '0;
      out_ixt <= '0;
      out_iyt <= '0;
    end else if (step) begin
      out_sof <= out_sof_d;
      out_eol <= out_eol_d;
      out_ixx <= prod[int'(PR_XX)];
      out_iyy <= prod[int'(PR_YY)];
      out_ixy <= prod[int'(PR_XY)];
      out_ixt <= prod[int'(PR_XT)];
      out_iyt <= prod[int'(PR_YT)];
    end
  end

  // Checks on the output port relations
  logic signed [2*PW-1:0] cs_lhs, cs_rhs, cs_xy, cs_xx, cs_yy;
  assign cs_xy  = out_ixy;
  assign cs_xx  = out_ixx;
  assign cs_yy  = out_iyy;
  assign cs_lhs = cs_xy * cs_xy;
  assign cs_rhs = cs_xx * cs_yy;

  a_r1_last_col_no_ix: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_eol) |-> (out_ixx == '0 && out_ixy == '0 && out_ixt == '0));

  a_r2_first_row_no_iy: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_sof) |-> (out_iyy == '0 && out_iyt == '0));

  a_r4_xx_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_ixx[PW-1]);

  a_r4_yy_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_iyy[PW-1]);

  a_r4_tensor_bound: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (cs_lhs <= cs_rhs));

  a_r6_sof_not_eol: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !(out_sof && out_eol));

  a_r8_no_take_in_drain: assert property (@(posedge clk) disable iff (!rst_n)
    flushing |=> !$past(eff_sof));

endmodule

// File: tb/grad_tensor_stage_test.sv
module grad_tensor_stage_test;

  localparam int W  = 6;
  localparam int H  = 5;
  localparam int PX = 8;
  localparam int PW = 2 * (PX + 2);
  localparam int N  = W * H;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0;
  logic in_sof = 1'b0;
  logic [PX-1:0] in_cur = '0;
  logic [PX-1:0] in_prev = '0;
  logic in_ready, out_valid, out_sof, out_eol;
  logic signed [PW-1:0] out_ixx, out_iyy, out_ixy, out_ixt, out_iyt;

  always #4 clk = ~clk;

  grad_tensor_stage #(.PIX_W(PX), .LINE_W(W), .LINES(H)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_sof(in_sof), .in_cur(in_cur), .in_prev(in_prev),
    .out_valid(out_valid), .out_sof(out_sof), .out_eol(out_eol),
    .out_ixx(out_ixx), .out_iyy(out_iyy), .out_ixy(out_ixy),
    .out_ixt(out_ixt), .out_iyt(out_iyt)
  );

  int n_chk = 0;
  int n_bad = 0;
  int cyc = 0;
  int got_n = 0;
  int first_cyc = -1;
  int acc_cyc = 0;
  int bad_hold = 0;
  logic stepped = 1'b0;

  int cur_f [H][W];
  int prev_f [H][W];
  int g_xx [N], g_yy [N], g_xy [N], g_xt [N], g_yt [N];
  logic g_sof [N], g_eol [N];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    stepped <= (in_valid && in_ready) || !in_ready;
  end

  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      if (!stepped) bad_hold++;
      if (got_n == 0) first_cyc = cyc;
      if (got_n < N) begin
        g_xx[got_n] = int'(out_ixx);
        g_yy[got_n] = int'(out_iyy);
        g_xy[got_n] = int'(out_ixy);
        g_xt[got_n] = int'(out_ixt);
        g_yt[got_n] = int'(out_iyt);
        g_sof[got_n] = out_sof;
        g_eol[got_n] = out_eol;
      end
      got_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input int got, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, got, exp);
    end
  endtask

  function automatic int gx(input int r, input int c);
    if (c == 0 || c == W - 1) return 0;
    return cur_f[r][c+1] - cur_f[r][c-1];
  endfunction

  function automatic int gy(input int r, input int c);
    if (r == 0 || r == H - 1) return 0;
    return cur_f[r+1][c] - cur_f[r-1][c];
  endfunction

  function automatic int gt(input int r, input int c);
    return cur_f[r][c] - prev_f[r][c];
  endfunction

  task automatic fill(input int mode);
    for (int r = 0; r < H; r++) begin
      for (int c = 0; c < W; c++) begin
        case (mode)
          0: begin cur_f[r][c] = $urandom_range(0, 255); prev_f[r][c] = $urandom_range(0, 255); end
          1: begin
               cur_f[r][c]  = (((r + c) % 3) == 0) ? 255 : 0;
               prev_f[r][c] = 255 - cur_f[r][c];
             end
          2: begin cur_f[r][c] = (r * 53 + c * 37) & 255; prev_f[r][c] = (c * 91 + 7) & 255; end
          default: begin cur_f[r][c] = (c % 2) ? 255 : 0; prev_f[r][c] = (r % 2) ? 0 : 255; end
        endcase
      end
    end
  endtask

  task automatic send(input int npix, input bit gaps, input bit garbage);
    for (int k = 0; k < npix; k++) begin
      if (gaps && $urandom_range(0, 2) == 0) begin
        @(negedge clk);
        in_valid = 1'b0;
        for (int g = 0; g < int'($urandom_range(0, 3)); g++) @(negedge clk);
      end
      @(negedge clk);
      while (!in_ready) @(negedge clk);
      in_valid = 1'b1;
      in_sof   = (k == 0);
      in_cur   = garbage ? PX'($urandom_range(0, 255)) : PX'(cur_f[k / W][k % W]);
      in_prev  = garbage ? PX'($urandom_range(0, 255)) : PX'(prev_f[k / W][k % W]);
      if (k == 0) acc_cyc = cyc + 1;
    end
    @(negedge clk);
    in_valid = 1'b0;
    in_sof   = 1'b0;
  endtask

  task automatic compare(input int fr);
    check(got_n == N, "R5", $sformatf("frame %0d output count", fr), got_n, N);
    for (int i = 0; i < N && i < got_n; i++) begin
      int r = i / W;
      int c = i % W;
      int ex = gx(r, c);
      int ey = gy(r, c);
      int et = gt(r, c);
      check(g_xx[i] == ex * ex, "R1", $sformatf("frame %0d pix %0d ixx", fr, i), g_xx[i], ex * ex);
      check(g_yy[i] == ey * ey, "R2", $sformatf("frame %0d pix %0d iyy", fr, i), g_yy[i], ey * ey);
      check(g_xy[i] == ex * ey, "R4", $sformatf("frame %0d pix %0d ixy", fr, i), g_xy[i], ex * ey);
      check(g_xt[i] == ex * et, "R3", $sformatf("frame %0d pix %0d ixt", fr, i), g_xt[i], ex * et);
      check(g_yt[i] == ey * et, "R3", $sformatf("frame %0d pix %0d iyt", fr, i), g_yt[i], ey * et);
      check(g_sof[i] == (i == 0), "R6", $sformatf("frame %0d pix %0d sof", fr, i), int'(g_sof[i]), int'(i == 0));
      check(g_eol[i] == (c == W - 1), "R6", $sformatf("frame %0d pix %0d eol", fr, i), int'(g_eol[i]), int'(c == W - 1));
    end
  endtask

  task automatic run_frame(input int fr, input int mode, input bit gaps);
    int low;
    fill(mode);
    got_n = 0;
    first_cyc = -1;
    send(N, gaps, 1'b0);
    low = 0;
    while (!in_ready) begin
      low++;
      @(negedge clk);
    end
    check(low == W + 1, "R8", $sformatf("frame %0d drain cycles", fr), low, W + 1);
    repeat (3) @(negedge clk);
    if (!gaps)
      check(first_cyc - acc_cyc == W + 1, "R7", $sformatf("frame %0d first output latency", fr),
            first_cyc - acc_cyc, W + 1);
    compare(fr);
  endtask

  task automatic summary();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R5", "reset out_valid", int'(out_valid), 0);
    check(in_ready == 1'b1, "R5", "reset in_ready", int'(in_ready), 1);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    run_frame(1, 0, 1'b0);
    run_frame(2, 1, 1'b0);
    run_frame(3, 2, 1'b0);

    // R9: random idle gaps must not change results or emit extra outputs
    bad_hold = 0;
    run_frame(4, 0, 1'b1);
    run_frame(5, 3, 1'b1);
    check(bad_hold == 0, "R9", "outputs in idle cycles", bad_hold, 0);

    // R10: abandon a frame part way, then restart with in_sof
    send(2 * W + 3, 1'b0, 1'b1);
    repeat (4) @(negedge clk);
    check(in_ready == 1'b1, "R10", "ready after partial frame", int'(in_ready), 1);
    run_frame(6, 0, 1'b0);
    check(got_n >= 1 && g_sof[0] == 1'b1, "R10", "restart first output sof", got_n, 1);

    run_frame(7, 3, 1'b0);

    summary();
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    summary();
    $finish;
  end

endmodule